// File: doc/BRIEF.md
# Interrupt Status Aggregator with Set and Clear Ports

This block collects interrupt events for a memory-mapped device into one shared status word of `DATA_W` bits. Two internal hardware events, a compute-done pulse and a DMA-done pulse, set their own fixed bits in that word. Software can also set any bit by writing a mask to the raise address. It clears bits by writing a mask to the acknowledge address.

A single level interrupt line is driven from a register. That register follows whether any status bit is set, one clock later. Software reads the status word back over a small register bus. The read data is registered, so it is valid one cycle after the read is issued.

When a hardware set and a software clear hit the same bit in the same cycle, the set wins, so no event is lost. The asynchronous active-low reset is released synchronously inside the block.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted, and until the first write or event after it is released, the status word is zero and `irq_o` and `reg_rdata` are low.
- R2: A one-cycle pulse on `hw_compute_done` sets status bit 0 (parameter `COMPUTE_BIT`) on the next clock edge.
- R3: A one-cycle pulse on `hw_dma_done` sets status bit 8 (parameter `DMA_BIT`) on the next clock edge.
- R4: A write to address 1 (raise) ORs `reg_wdata` into the status word. Any bit may be raised, not only the two hardware bits.
- R5: A write to address 2 (acknowledge) clears exactly the status bits that are 1 in `reg_wdata` and leaves every other bit unchanged.
- R6: If a hardware event and an acknowledge target the same bit in the same cycle, that bit ends up set.
- R7: `irq_o` is registered. After each clock edge it equals 1 exactly when the status word was nonzero before that edge, so it falls only after every bit has been cleared.
- R8: A read (`reg_rd` high) at address 0 loads the status word into `reg_rdata` on that edge. A read at any other address loads zero. Without a read, `reg_rdata` holds its value.
- R9: Writes to address 0 (status) and address 3 (unused) do not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_compute_done | input | 1 | Compute-complete event pulse |
| hw_dma_done | input | 1 | DMA-complete event pulse |
| reg_addr | input | 2 | Register address: 0 status, 1 raise, 2 acknowledge, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data (mask) |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, high while any status bit is set (one cycle late) |

## Verification
Two things can land on the same cycle. One is a hardware event together with an acknowledge write whose mask covers that event's bit. The other is a read sampled in the same cycle as a write or event. A directed case pulses `hw_compute_done` while acknowledging bit 0, then reads the word back; bit 0 must still be set. Random cycles fire both event pulses at a low rate under random raise, acknowledge and read traffic, so the same collisions recur. Every `reg_rdata` and `irq_o` value is compared with a bench model in which set takes priority over clear and reads return the word as it stood before the edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_RAISE  = 2'd1,
    REG_ACK    = 2'd2,
    REG_SPARE  = 2'd3
  } irq_reg_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int COMPUTE_BIT = 0,
  parameter int DMA_BIT     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_compute_done,
  input  logic              hw_dma_done,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] hw_mask;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rdata_en;
  irq_reg_e          addr_e;

  always_comb begin
    addr_e  = irq_reg_e'(reg_addr);
    hw_mask = '0;
    hw_mask[COMPUTE_BIT] = hw_compute_done;
    hw_mask[DMA_BIT]     = hw_mask[DMA_BIT] | hw_dma_done;

    set_mask = hw_mask;
    clr_mask = '0;
    if (reg_wr) begin
      unique case (addr_e)
        REG_RAISE: set_mask = hw_mask | reg_wdata;
        REG_ACK:   clr_mask = reg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_en = reg_rd;
    rdata_d  = (addr_e == REG_STATUS) ? status_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] status_d;
  logic              status_en;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    // set has priority over clear so a coincident event is kept
    assign status_d[b] = set_mask[b] | (status_q[b] & ~clr_mask[b]);
  end

  assign status_en = (|set_mask) | (|clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/irq_level_out.sv
module irq_level_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_q,
  output logic              irq_o
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int COMPUTE_BIT = 0,
  parameter int DMA_BIT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_compute_done,
  input  logic              hw_dma_done,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic              rst_int_n;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_reg_port #(
    .DATA_W      (DATA_W),
    .COMPUTE_BIT (COMPUTE_BIT),
    .DMA_BIT     (DMA_BIT)
  ) u_port (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .hw_compute_done (hw_compute_done),
    .hw_dma_done     (hw_dma_done),
    .reg_addr        (reg_addr),
    .reg_wr          (reg_wr),
    .reg_wdata       (reg_wdata),
    .reg_rd          (reg_rd),
    .status_q        (status_q),
    .set_mask        (set_mask),
    .clr_mask        (clr_mask),
    .reg_rdata       (reg_rdata)
  );

  irq_status_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .status_q (status_q)
  );

  irq_level_out #(.DATA_W(DATA_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .status_q (status_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int COMPUTE_BIT = 0,
  parameter int DMA_BIT     = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              hw_compute_done,
  input logic              hw_dma_done,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] status_q,
  input logic              irq_o
);
  logic hw_any;
  assign hw_any = hw_compute_done | hw_dma_done;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_int_n |-> (status_q == '0 && !irq_o && reg_rdata == '0));

  assert_compute_sets_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    hw_compute_done |=> status_q[COMPUTE_BIT]);

  assert_dma_sets_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    hw_dma_done |=> status_q[DMA_BIT]);

  assert_raise_or_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_addr == REG_RAISE) |=> ((status_q & $past(reg_wdata)) == $past(reg_wdata)));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_addr == REG_ACK && !hw_any) |=> ((status_q & $past(reg_wdata)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hw_compute_done && reg_wr && reg_addr == REG_ACK) |=> status_q[COMPUTE_BIT]);

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (irq_o == ($past(status_q) != '0)));

  assert_read_back_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rd && reg_addr == REG_STATUS) |=> (reg_rdata == $past(status_q)));

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && (reg_addr == REG_STATUS || reg_addr == REG_SPARE) && !hw_any) |=> $stable(status_q));
endmodule

bind irq_status_agg irq_status_agg_chk #(
  .DATA_W      (DATA_W),
  .COMPUTE_BIT (COMPUTE_BIT),
  .DMA_BIT     (DMA_BIT)
) u_chk (
  .clk             (clk),
  .rst_int_n       (rst_int_n),
  .hw_compute_done (hw_compute_done),
  .hw_dma_done     (hw_dma_done),
  .reg_addr        (reg_addr),
  .reg_wr          (reg_wr),
  .reg_wdata       (reg_wdata),
  .reg_rd          (reg_rd),
  .reg_rdata       (reg_rdata),
  .status_q        (status_q),
  .irq_o           (irq_o)
);

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;
  localparam int W = 32;

  logic          clk;
  logic          rst_n;
  logic          hw_compute_done;
  logic          hw_dma_done;
  logic [1:0]    reg_addr;
  logic          reg_wr;
  logic [W-1:0]  reg_wdata;
  logic          reg_rd;
  logic [W-1:0]  reg_rdata;
  logic          irq_o;

  int            checks;
  int            failures;
  int            cycles;
  bit            done;
  logic [W-1:0]  exp_status;

  irq_status_agg uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .hw_compute_done (hw_compute_done),
    .hw_dma_done     (hw_dma_done),
    .reg_addr        (reg_addr),
    .reg_wr          (reg_wr),
    .reg_wdata       (reg_wdata),
    .reg_rd          (reg_rd),
    .reg_rdata       (reg_rdata),
    .irq_o           (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] model_next(
    input logic [W-1:0] s, input bit wr, input logic [1:0] a,
    input logic [W-1:0] wd, input bit cmp, input bit dma);
    logic [W-1:0] setm;
    logic [W-1:0] clrm;
    setm = '0;
    clrm = '0;
    setm[0] = cmp;
    setm[8] = dma;
    if (wr && a == 2'd1) setm = setm | wd;
    if (wr && a == 2'd2) clrm = wd;
    return setm | (s & ~clrm);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one bus cycle: drive at negedge, sample at the following negedge
  task automatic step(input bit wr, input logic [1:0] a, input logic [W-1:0] wd,
                      input bit rd, input bit cmp, input bit dma, input string tag);
    logic [W-1:0] old;
    old = exp_status;
    reg_wr = wr; reg_addr = a; reg_wdata = wd; reg_rd = rd;
    hw_compute_done = cmp; hw_dma_done = dma;
    @(posedge clk);
    @(negedge clk);
    exp_status = model_next(old, wr, a, wd, cmp, dma);
    check("R7 irq_o", {31'd0, irq_o}, {31'd0, (old != '0)});
    if (rd) check(tag, reg_rdata, (a == 2'd0) ? old : '0);
    reg_wr = 1'b0; reg_rd = 1'b0; hw_compute_done = 1'b0; hw_dma_done = 1'b0;
  endtask

  task automatic read_status(input string tag);
    step(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; cycles = 0; done = 1'b0;
    exp_status = '0;
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    hw_compute_done = 1'b0; hw_dma_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq_o}, '0);
    check("R1 rdata in reset", reg_rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {31'd0, irq_o}, '0);
    read_status("R1 status after reset");

    step(1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0, "R2");
    read_status("R2 compute bit");
    step(1'b1, 2'd2, 32'h0000_0001, 1'b0, 1'b0, 1'b0, "R5");
    read_status("R5 ack compute");
    step(1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1, "R3");
    read_status("R3 dma bit");
    step(1'b1, 2'd1, 32'hA5A5_0000, 1'b0, 1'b0, 1'b0, "R4");
    read_status("R4 raise arbitrary");
    step(1'b1, 2'd2, 32'h0000_0100, 1'b0, 1'b0, 1'b0, "R5");
    read_status("R5 partial ack");
    step(1'b1, 2'd2, 32'h0000_0001, 1'b0, 1'b1, 1'b0, "R6");
    read_status("R6 set beats clear");
    step(1'b1, 2'd2, 32'h0000_0100, 1'b1, 1'b0, 1'b1, "R6 dma read");
    read_status("R6 dma set beats clear");
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R9");
    read_status("R9 write to status ignored");
    step(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R9");
    read_status("R9 write to spare ignored");
    step(1'b0, 2'd1, '0, 1'b1, 1'b0, 1'b0, "R8 read other address is zero");
    step(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0, "R7");
    check("R7 irq low after full clear", {31'd0, irq_o}, '0);
    read_status("R5 all cleared");

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic [W-1:0] wd;
      sel = $urandom % 4;
      case (sel)
        0: wd = 32'h1 << ($urandom % W);
        1: wd = $urandom;
        2: wd = 32'h0000_0101;
        default: wd = 32'hFFFF_FFFF;
      endcase
      step(($urandom % 2) == 0, 2'($urandom % 4), wd, ($urandom % 2) == 0,
           ($urandom % 8) == 0, ($urandom % 8) == 0, "R8 random read");
    end
    finish_run();
  end
endmodule